// File: doc/BRIEF.md
# Reference Input Selection Controller

This block chooses which of four candidate reference clocks drives a downstream phase-locked loop. Each candidate arrives as a single-cycle edge pulse that has already been synchronised into the system clock domain. A loss-of-signal monitor watches each candidate and raises an alarm when the candidate goes quiet. The alarm stays set until the candidate proves itself again over several observation windows.

The selector runs in one of three modes: manual, automatic non-revertive or automatic revertive. In manual mode an external 2-bit select picks the input, and the select is filtered so that a short disturbance on it cannot cause a switch. In the two automatic modes the block chooses by fixed priority, with input 1 the highest and input 4 the lowest. When no usable input exists, the block enters holdover and raises a flag. The loop uses that flag to freeze its frequency control.

There are two kinds of state machine. Each input monitor has the states MON_VALID and MON_LOST. It moves from MON_VALID to MON_LOST on loss of signal, and from MON_LOST to MON_VALID on revalidation. The selector has the states ST_TRACK and ST_HOLDOVER. It moves from ST_TRACK to ST_HOLDOVER when no usable input remains, and from ST_HOLDOVER to ST_TRACK when a usable input appears. While it stays in ST_TRACK, it can also move to another input when the mode rules call for a switch.

Top module: `clksel_ctrl`

## Requirements
- R1: An input's alarm rises on the clock edge that completes LOS_WIN consecutive sampled cycles without an edge on that input (LOS_WIN defaults to 64). A gap of LOS_WIN-1 cycles leaves the alarm low.
- R2: An alarm is sticky. Observation windows of LOS_WIN cycles start on the edge after the alarm rises. The alarm clears only at the end of VAL_WIN consecutive windows that each contained at least one edge (VAL_WIN defaults to 4). A window with no edge restarts the count.
- R3: While rst_n is low, and until the inputs change the state, every alarm is set, holdover is 1, active_onehot is all zero, and the accepted manual select is 00.
- R4: mode_sel encoding: 00 = manual, 01 = automatic non-revertive, 10 = automatic revertive, 11 = manual.
- R5: In manual mode the accepted select maps 00, 01, 10 and 11 to inputs 1, 2, 3 and 4. If the selected input is alarmed, the block enters holdover and does not fall back to another input.
- R6: A new man_sel value is accepted only after it has been held for DGL_LEN consecutive cycles (DGL_LEN defaults to 16). The active indicator follows one cycle after acceptance. A shorter excursion has no effect.
- R7: In revertive mode the active input is always the highest-priority input that is not alarmed, with input 1 highest. The selector reaches that input on the edge after its alarm clears.
- R8: In non-revertive mode the current input is kept for as long as it is not alarmed, even when a higher-priority input becomes valid. When the current input fails, the selector moves to the highest-priority valid input.
- R9: active_onehot has bit i set only for input i+1 while that input feeds the loop. It has at most one bit set, and it is all zero in holdover.
- R10: los_alarm[2:0] report the alarms of inputs 3 down to 1. alarm_out is the alarm of input 4 ORed with holdover.
- R11: Holdover is asserted when no usable input exists: in automatic modes, every input is alarmed; in manual mode, the selected input is alarmed. Holdover drops on the clock edge after a usable input's alarm clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_in | input | N_IN | Synchronised edge pulse per input; bit 0 is input 1 |
| mode_sel | input | 2 | Selection mode (R4) |
| man_sel | input | log2(N_IN) | Manual input select, before filtering |
| active_onehot | output | N_IN | Active-input indicator |
| los_alarm | output | N_IN-1 | Alarms of inputs 1 to N_IN-1 |
| alarm_out | output | 1 | Alarm of the last input ORed with holdover |
| holdover | output | 1 | Freeze request to the loop |

## Verification
The bench builds the block with LOS_WIN=8, VAL_WIN=2 and DGL_LEN=4. With these values a loss, a full revalidation and a select acceptance each take only tens of cycles. Every mode transition in the vector table therefore settles within a fixed 40-cycle wait. The short windows also let directed tests probe the exact edge at which an alarm rises and the exact cycle at which a filtered select takes effect. They also make it cheap to show that one good window is not enough to revalidate an input.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    // Selection mode encoding (R4)
    typedef enum logic [1:0] {
        MODE_MANUAL      = 2'b00,
        MODE_AUTO_NONREV = 2'b01,
        MODE_AUTO_REV    = 2'b10,
        MODE_MANUAL_ALT  = 2'b11
    } sel_mode_e;

    // Per-input monitor states
    typedef enum logic {
        MON_VALID = 1'b0,
        MON_LOST  = 1'b1
    } mon_state_e;

    // Selector states
    typedef enum logic {
        ST_HOLDOVER = 1'b0,
        ST_TRACK    = 1'b1
    } sel_state_e;

endpackage

// File: rtl/clksel_los_mon.sv
module clksel_los_mon
    import clksel_pkg::*;
#(
    parameter int LOS_WIN = 64,
    parameter int VAL_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic alarm_o
);

    localparam int CW = $clog2(LOS_WIN + 1);
    localparam int VW = $clog2(VAL_WIN + 1);

    mon_state_e     st_q, st_d;
    logic [CW-1:0]  gap_q;
    logic [CW-1:0]  win_q;
    logic           seen_q;
    logic [VW-1:0]  good_q;
    logic           win_end;
    logic           win_hit;

    assign win_end = (win_q == CW'(LOS_WIN - 1));
    assign win_hit = seen_q | edge_i;

    // Count the sampled cycles since the last edge, saturating at LOS_WIN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (edge_i) begin
            gap_q <= '0;
        end else if (gap_q != CW'(LOS_WIN)) begin
            gap_q <= gap_q + CW'(1);
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MON_VALID: begin
                if (!edge_i && gap_q >= CW'(LOS_WIN - 1)) begin
                    st_d = MON_LOST;
                end
            end
            MON_LOST: begin
                if (win_end && win_hit && good_q == VW'(VAL_WIN - 1)) begin
                    st_d = MON_VALID;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= MON_LOST;
        end else begin
            st_q <= st_d;
        end
    end

    // Revalidation windows run only while the input is in alarm.
    always_ff @(posedge clk) begin
        if (!rst_n || st_q == MON_VALID) begin
            win_q  <= '0;
            seen_q <= 1'b0;
            good_q <= '0;
        end else if (win_end) begin
            win_q  <= '0;
            seen_q <= 1'b0;
            if (win_hit && good_q != VW'(VAL_WIN - 1)) begin
                good_q <= good_q + VW'(1);
            end else begin
                good_q <= '0;
            end
        end else begin
            win_q  <= win_q + CW'(1);
            seen_q <= win_hit;
        end
    end

    always_comb begin
        alarm_o = (st_q == MON_LOST);
    end

endmodule

// File: rtl/clksel_deglitch.sv
module clksel_deglitch #(
    parameter int W    = 2,
    parameter int HOLD = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sel_o
);

    localparam int CW = $clog2(HOLD + 1);

    logic [W-1:0]  acc_q;
    logic [W-1:0]  cand_q;
    logic [CW-1:0] cnt_q;

    // A new value is accepted once it has been seen HOLD consecutive
    // cycles; HOLD must be at least 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cand_q <= '0;
            cnt_q  <= '0;
        end else if (raw_i == acc_q) begin
            cand_q <= raw_i;
            cnt_q  <= '0;
        end else if (raw_i != cand_q) begin
            cand_q <= raw_i;
            cnt_q  <= CW'(1);
        end else if (cnt_q == CW'(HOLD - 1)) begin
            acc_q  <= raw_i;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign sel_o = acc_q;

endmodule

// File: rtl/clksel_fsm.sv
module clksel_fsm
    import clksel_pkg::*;
#(
    parameter int N_IN = 4,
    localparam int SEL_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [SEL_W-1:0] man_i,
    input  logic [N_IN-1:0]  los_i,
    output logic [N_IN-1:0]  active_o,
    output logic             hold_o
);

    sel_state_e       st_q, st_d;
    logic [SEL_W-1:0] idx_q, idx_d;
    logic [SEL_W-1:0] best;
    logic             any_ok;
    sel_mode_e        mode;

    assign mode = sel_mode_e'(mode_i);

    // Highest-priority input not in alarm; input 1 (index 0) wins.
    always_comb begin
        best   = '0;
        any_ok = 1'b0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (!los_i[i]) begin
                best   = SEL_W'(i);
                any_ok = 1'b1;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        unique case (mode)
            MODE_AUTO_REV: begin
                if (any_ok) begin
                    st_d  = ST_TRACK;
                    idx_d = best;
                end else begin
                    st_d  = ST_HOLDOVER;
                end
            end
            MODE_AUTO_NONREV: begin
                if (st_q == ST_TRACK && !los_i[idx_q]) begin
                    st_d = ST_TRACK;
                end else if (any_ok) begin
                    st_d  = ST_TRACK;
                    idx_d = best;
                end else begin
                    st_d  = ST_HOLDOVER;
                end
            end
            MODE_MANUAL, MODE_MANUAL_ALT: begin
                idx_d = man_i;
                st_d  = los_i[man_i] ? ST_HOLDOVER : ST_TRACK;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HOLDOVER;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    // Outputs.
    always_comb begin
        hold_o   = 1'b1;
        active_o = '0;
        unique case (st_q)
            ST_TRACK: begin
                hold_o   = 1'b0;
                active_o = N_IN'(1) << idx_q;
            end
            ST_HOLDOVER: begin
                hold_o   = 1'b1;
                active_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int N_IN    = 4,
    parameter int LOS_WIN = 64,
    parameter int VAL_WIN = 4,
    parameter int DGL_LEN = 16,
    localparam int SEL_W  = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  edge_in,
    input  logic [1:0]       mode_sel,
    input  logic [SEL_W-1:0] man_sel,
    output logic [N_IN-1:0]  active_onehot,
    output logic [N_IN-2:0]  los_alarm,
    output logic             alarm_out,
    output logic             holdover
);

    logic [N_IN-1:0]  los_vec;
    logic [SEL_W-1:0] man_acc;

    for (genvar g = 0; g < N_IN; g++) begin : g_mon
        clksel_los_mon #(
            .LOS_WIN (LOS_WIN),
            .VAL_WIN (VAL_WIN)
        ) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .edge_i  (edge_in[g]),
            .alarm_o (los_vec[g])
        );
    end

    clksel_deglitch #(
        .W    (SEL_W),
        .HOLD (DGL_LEN)
    ) u_dgl (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (man_sel),
        .sel_o (man_acc)
    );

    clksel_fsm #(
        .N_IN (N_IN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_sel),
        .man_i    (man_acc),
        .los_i    (los_vec),
        .active_o (active_onehot),
        .hold_o   (holdover)
    );

    assign los_alarm = los_vec[N_IN-2:0];
    assign alarm_out = los_vec[N_IN-1] | holdover;

endmodule

// File: rtl/clksel_ctrl_chk.sv
module clksel_ctrl_chk #(
    parameter int N_IN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] edge_in,
    input logic [1:0]      mode_sel,
    input logic [N_IN-1:0] active_onehot,
    input logic            holdover,
    input logic [N_IN-1:0] los_vec
);

    // R9
    onehot_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_onehot));

    // R9
    active_not_alarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|active_onehot) |-> ((active_onehot & $past(los_vec)) == '0));

    // R7
    revert_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && !los_vec[0]) |=> active_onehot[0]);

    // R8
    nonrev_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 && (|active_onehot) && ((active_onehot & los_vec) == '0))
        |=> $stable(active_onehot));

    // R11
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(holdover) |-> ($past(los_vec) != '1));

    for (genvar g = 0; g < N_IN; g++) begin : g_los
        // R1
        los_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(los_vec[g]) |-> !$past(edge_in[g]));
    end

endmodule

bind clksel_ctrl clksel_ctrl_chk #(.N_IN(N_IN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .edge_in       (edge_in),
    .mode_sel      (mode_sel),
    .active_onehot (active_onehot),
    .holdover      (holdover),
    .los_vec       (los_vec)
);

// File: tb/tb_clksel_ctrl.sv
module tb_clksel_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N_IN    = 4;
    localparam int LOS_WIN = 8;
    localparam int VAL_WIN = 2;
    localparam int DGL_LEN = 4;
    localparam int SETTLE  = 40;
    localparam int NVEC    = 15;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N_IN-1:0]  edge_in;
    logic [1:0]       mode_sel;
    logic [1:0]       man_sel;
    logic [N_IN-1:0]  active_onehot;
    logic [N_IN-2:0]  los_alarm;
    logic             alarm_out;
    logic             holdover;

    logic [N_IN-1:0]  live;
    logic [N_IN-1:0]  fast;
    logic             ph;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Edge pulses: every cycle for fast inputs, every other cycle otherwise.
    always @(negedge clk) ph <= ~ph;
    assign edge_in = live & (fast | {N_IN{ph}});

    clksel_ctrl #(
        .N_IN    (N_IN),
        .LOS_WIN (LOS_WIN),
        .VAL_WIN (VAL_WIN),
        .DGL_LEN (DGL_LEN)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .edge_in       (edge_in),
        .mode_sel      (mode_sel),
        .man_sel       (man_sel),
        .active_onehot (active_onehot),
        .los_alarm     (los_alarm),
        .alarm_out     (alarm_out),
        .holdover      (holdover)
    );

    // {mode, sel, live[4:1], exp active, exp los[3:1], exp alarm_out, exp holdover}
    localparam logic [16:0] VEC [NVEC] = '{
        {2'b10, 2'b00, 4'b1111, 4'b0001, 3'b000, 1'b0, 1'b0},
        {2'b10, 2'b00, 4'b1110, 4'b0010, 3'b001, 1'b0, 1'b0},
        {2'b10, 2'b00, 4'b1111, 4'b0001, 3'b000, 1'b0, 1'b0},
        {2'b01, 2'b00, 4'b1110, 4'b0010, 3'b001, 1'b0, 1'b0},
        {2'b01, 2'b00, 4'b1111, 4'b0010, 3'b000, 1'b0, 1'b0},
        {2'b01, 2'b00, 4'b1011, 4'b0010, 3'b100, 1'b0, 1'b0},
        {2'b01, 2'b00, 4'b1001, 4'b0001, 3'b110, 1'b0, 1'b0},
        {2'b01, 2'b00, 4'b0000, 4'b0000, 3'b111, 1'b1, 1'b1},
        {2'b01, 2'b00, 4'b1000, 4'b1000, 3'b111, 1'b0, 1'b0},
        {2'b00, 2'b11, 4'b1000, 4'b1000, 3'b111, 1'b0, 1'b0},
        {2'b00, 2'b00, 4'b1000, 4'b0000, 3'b111, 1'b1, 1'b1},
        {2'b00, 2'b00, 4'b1111, 4'b0001, 3'b000, 1'b0, 1'b0},
        {2'b00, 2'b10, 4'b1111, 4'b0100, 3'b000, 1'b0, 1'b0},
        {2'b00, 2'b01, 4'b1111, 4'b0010, 3'b000, 1'b0, 1'b0},
        {2'b10, 2'b00, 4'b0111, 4'b0001, 3'b000, 1'b1, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b01:   return "R8 active (non-revertive)";
            2'b10:   return "R7 active (revertive)";
            default: return "R5 active (manual)";
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        ph       = 1'b0;
        rst_n    = 1'b0;
        live     = '0;
        fast     = '0;
        mode_sel = 2'b00;
        man_sel  = 2'b00;
        tick(4);
        // R3 reset state
        chk("R3 active", 32'(active_onehot), 32'h0);
        chk("R3 los", 32'(los_alarm), 32'h7);
        chk("R3 alarm_out", 32'(alarm_out), 32'h1);
        chk("R3 holdover", 32'(holdover), 32'h1);
        rst_n = 1'b1;
        tick(2);
        chk("R3 holdover after release", 32'(holdover), 32'h1);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            mode_sel = VEC[v][16:15];
            man_sel  = VEC[v][14:13];
            live     = VEC[v][12:9];
            tick(SETTLE);
            chk(mode_tag(VEC[v][16:15]), 32'(active_onehot), 32'(VEC[v][8:5]));
            chk("R1 R2 los alarms", 32'(los_alarm), 32'(VEC[v][4:2]));
            chk("R10 alarm_out", 32'(alarm_out), 32'(VEC[v][1]));
            chk("R11 holdover", 32'(holdover), 32'(VEC[v][0]));
        end

        // R4: mode 11 behaves as manual
        mode_sel = 2'b11;
        man_sel  = 2'b10;
        live     = 4'b1111;
        tick(SETTLE);
        chk("R4 mode 11 manual", 32'(active_onehot), 32'h4);

        // R6: deglitched select
        mode_sel = 2'b00;
        man_sel  = 2'b00;
        tick(SETTLE);
        chk("R6 base select", 32'(active_onehot), 32'h1);
        man_sel = 2'b01;
        tick(DGL_LEN - 1);
        man_sel = 2'b00;
        tick(2 * DGL_LEN);
        chk("R6 short excursion ignored", 32'(active_onehot), 32'h1);
        man_sel = 2'b01;
        tick(DGL_LEN);
        chk("R6 not yet switched", 32'(active_onehot), 32'h1);
        tick(1);
        chk("R6 switched after hold", 32'(active_onehot), 32'h2);

        // R1: gap boundary on input 2 with an edge every cycle
        fast[1] = 1'b1;
        tick(4);
        live[1] = 1'b0;
        tick(LOS_WIN - 1);
        live[1] = 1'b1;
        tick(2);
        chk("R1 short gap no alarm", 32'(los_alarm[1]), 32'h0);
        live[1] = 1'b0;
        tick(LOS_WIN - 1);
        chk("R1 alarm not before window", 32'(los_alarm[1]), 32'h0);
        tick(1);
        chk("R1 alarm at window", 32'(los_alarm[1]), 32'h1);
        chk("R11 holdover not yet", 32'(holdover), 32'h0);
        tick(1);
        chk("R11 manual selected alarmed", 32'(holdover), 32'h1);
        chk("R5 no fallback", 32'(active_onehot), 32'h0);
        chk("R10 alarm_out in holdover", 32'(alarm_out), 32'h1);

        // R2: one good window is not enough
        live[1] = 1'b1;
        tick(LOS_WIN);
        chk("R2 still alarmed after one window", 32'(los_alarm[1]), 32'h1);
        for (int k = 0; k < 4 * LOS_WIN && los_alarm[1]; k++) tick(1);
        chk("R2 alarm cleared", 32'(los_alarm[1]), 32'h0);
        chk("R11 holdover one cycle late", 32'(holdover), 32'h1);
        tick(1);
        chk("R11 holdover exit", 32'(holdover), 32'h0);
        chk("R9 active after exit", 32'(active_onehot), 32'h2);

        finish_run();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule